// File: doc/BRIEF.md
# Single/Double-Clock Output Port Multiplexer

This block places a 16-bit output pixel word on two 8-bit output ports. It has two modes. In single-clock mode the two ports together carry the whole word on every clock: port A has the upper byte and port B has the lower byte. In double-clock mode port A alone carries the word as two bytes, the upper byte first and then the lower byte. Port B is then free to act as an 8-bit general-purpose output, driven from a configuration value.

A word strobe marks the clock in which a new word is accepted. That clock always starts a new byte sequence, so the upper byte is always sent first. A separate routing bit chooses where a vertical-blanking-active qualifier appears. It goes either to the video-active pin, in place of the normal video-active signal, or to the test-data-out pin, which otherwise stays low. Every output is registered and appears one clock after the inputs that produce it. Pad drivers are outside this block.

Top module: `outport_mux`

## Requirements
- R1: In single-clock mode (`cfg_i[0]`=0), one clock after a strobed clock, port A shows bits [15:8] of the strobed word. In later clocks with no strobe, port A keeps showing those bits.
- R2: In double-clock mode (`cfg_i[0]`=1), one clock after a strobed clock, port A shows bits [15:8] of the word. After each later clock with no strobe, port A shows bits [7:0] of the held word.
- R3: In double-clock mode with the output-enable bit `cfg_i[1]`=1, port B shows the general-purpose value `cfg_i[10:3]` one clock later.
- R4: In single-clock mode, port B shows bits [7:0] of the most recently strobed word. The enable bit and the value field have no effect on port B.
- R5: In double-clock mode with `cfg_i[1]`=0, port B is 0 one clock later.
- R6: With the routing bit `cfg_i[2]`=1, one clock later `tdo_o` shows the blanking qualifier and `vact_o` shows the video-active input.
- R7: With `cfg_i[2]`=0, one clock later `vact_o` shows the blanking qualifier and `tdo_o` is 0.
- R8: In double-clock mode, a strobe that falls in the clock where the lower byte would have been sent starts a new sequence. Port A shows the upper byte of the new word, and the lower byte of the previous word is never sent.
- R9: While `rst_n` is low, all four outputs are 0 and the held word is 0. Until the first strobe, port A and port B then show 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_word_i | input | 16 | Output pixel word |
| word_stb_i | input | 1 | Word accepted in this clock |
| cfg_i | input | 11 | [0] double-clock mode, [1] general-output enable, [2] qualifier to test pin, [10:3] general-output value |
| vbi_act_i | input | 1 | Vertical-blanking-active qualifier |
| vid_act_i | input | 1 | Normal video-active qualifier |
| port_a_o | output | 8 | Port A byte |
| port_b_o | output | 8 | Port B byte |
| vact_o | output | 1 | Video-active pin |
| tdo_o | output | 1 | Test-data-out pin |

## Verification
In double-clock mode, a new word strobe can fall in the same clock as the lower-byte slot of the previous word. This is provoked by running phases in which the strobe comes every clock, every second clock and every third clock, with random words.

The reference model in the bench gives the upper byte of the new word priority in that clock. Port A is compared against the model after every clock, so a design that lets the old lower byte through is reported under R8. The mode, the enable bit and the routing bit are also changed at random in the same clocks as strobes, so these changes are tested where they coincide with strobes.

// File: rtl/outport_mux_pkg.sv
package outport_mux_pkg;
   localparam int unsigned CFG_DBL_BIT   = 0;
   localparam int unsigned CFG_GPO_EN    = 1;
   localparam int unsigned CFG_QUAL_TDO  = 2;
   localparam int unsigned CFG_GPO_LSB   = 3;
   localparam int unsigned CFG_FIXED_W   = 3;

   typedef enum logic {
      MODE_SINGLE = 1'b0,
      MODE_DOUBLE = 1'b1
   } port_mode_e;

   function automatic int unsigned cfg_width(input int unsigned byte_w);
      return byte_w + CFG_FIXED_W;
   endfunction
endpackage

// File: rtl/omx_word_hold.sv
module omx_word_hold #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb_i,
   input  logic [WORD_W-1:0] word_i,
   input  outport_mux_pkg::port_mode_e mode_i,
   output logic [BYTE_W-1:0] lo_eff_o,
   output logic [BYTE_W-1:0] port_a_o
);
   import outport_mux_pkg::*;

   logic [WORD_W-1:0] held_q;
   logic [WORD_W-1:0] word_eff;
   logic [BYTE_W-1:0] byte_lane [2];
   logic [BYTE_W-1:0] a_next;

   assign word_eff = stb_i ? word_i : held_q;

   for (genvar g = 0; g < 2; g++) begin : g_lane
      assign byte_lane[g] = word_eff[g*BYTE_W +: BYTE_W];
   end

   assign lo_eff_o = byte_lane[0];

   always_comb begin
      if (mode_i == MODE_DOUBLE && !stb_i) a_next = byte_lane[0];
      else                                 a_next = byte_lane[1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q   <= '0;
         port_a_o <= '0;
      end else begin
         if (stb_i) held_q <= word_i;
         port_a_o <= a_next;
      end
   end

   AST_SGL_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && mode_i == MODE_SINGLE) |=> port_a_o == $past(word_i[WORD_W-1:BYTE_W])); // R1
   AST_SGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_i && mode_i == MODE_SINGLE) |=> port_a_o == $past(held_q[WORD_W-1:BYTE_W])); // R1
   AST_DBL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && mode_i == MODE_DOUBLE) |=> port_a_o == $past(word_i[WORD_W-1:BYTE_W])); // R8
   AST_DBL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (!stb_i && mode_i == MODE_DOUBLE) |=> port_a_o == $past(held_q[BYTE_W-1:0])); // R2
endmodule

// File: rtl/omx_portb_sel.sv
module omx_portb_sel #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  outport_mux_pkg::port_mode_e mode_i,
   input  logic              gpo_en_i,
   input  logic [BYTE_W-1:0] gpo_val_i,
   input  logic [BYTE_W-1:0] lo_eff_i,
   output logic [BYTE_W-1:0] port_b_o
);
   import outport_mux_pkg::*;

   logic [BYTE_W-1:0] b_next;

   always_comb begin
      unique case (mode_i)
         MODE_SINGLE: b_next = lo_eff_i;
         MODE_DOUBLE: b_next = gpo_en_i ? gpo_val_i : '0;
         default:     b_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) port_b_o <= '0;
      else        port_b_o <= b_next;
   end

   AST_GPO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_DOUBLE && gpo_en_i) |=> port_b_o == $past(gpo_val_i)); // R3
   AST_GPO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_DOUBLE && !gpo_en_i) |=> port_b_o == '0); // R5
   AST_SGL_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == MODE_SINGLE) |=> port_b_o == $past(lo_eff_i)); // R4
endmodule

// File: rtl/omx_qual_route.sv
module omx_qual_route #(
   parameter bit REG_QUAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic to_tdo_i,
   input  logic vbi_i,
   input  logic vid_i,
   output logic vact_o,
   output logic tdo_o
);
   logic vact_next;
   logic tdo_next;

   assign vact_next = to_tdo_i ? vid_i : vbi_i;
   assign tdo_next  = to_tdo_i & vbi_i;

   if (REG_QUAL) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vact_o <= 1'b0;
            tdo_o  <= 1'b0;
         end else begin
            vact_o <= vact_next;
            tdo_o  <= tdo_next;
         end
      end

      AST_TDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !to_tdo_i |=> !tdo_o); // R7
      AST_VBI_ON_VACT: assert property (@(posedge clk) disable iff (!rst_n)
         !to_tdo_i |=> vact_o == $past(vbi_i)); // R7
      AST_VBI_ON_TDO: assert property (@(posedge clk) disable iff (!rst_n)
         to_tdo_i |=> (tdo_o == $past(vbi_i)) && (vact_o == $past(vid_i))); // R6
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk & rst_n;
      assign vact_o = vact_next;
      assign tdo_o  = tdo_next;
   end
endmodule

// File: rtl/outport_mux.sv
module outport_mux #(
   parameter int unsigned BYTE_W   = 8,
   parameter bit          REG_QUAL = 1'b1,
   localparam int unsigned WORD_W  = 2 * BYTE_W,
   localparam int unsigned CFG_W   = outport_mux_pkg::cfg_width(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] pix_word_i,
   input  logic              word_stb_i,
   input  logic [CFG_W-1:0]  cfg_i,
   input  logic              vbi_act_i,
   input  logic              vid_act_i,
   output logic [BYTE_W-1:0] port_a_o,
   output logic [BYTE_W-1:0] port_b_o,
   output logic              vact_o,
   output logic              tdo_o
);
   import outport_mux_pkg::*;

   initial begin
      assert (BYTE_W >= 2) else $error("outport_mux: BYTE_W must be at least 2");
   end

   port_mode_e        mode;
   logic [BYTE_W-1:0] lo_eff;

   assign mode = port_mode_e'(cfg_i[CFG_DBL_BIT]);

   omx_word_hold #(.BYTE_W(BYTE_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb_i    (word_stb_i),
      .word_i   (pix_word_i),
      .mode_i   (mode),
      .lo_eff_o (lo_eff),
      .port_a_o (port_a_o)
   );

   omx_portb_sel #(.BYTE_W(BYTE_W)) u_portb (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode),
      .gpo_en_i  (cfg_i[CFG_GPO_EN]),
      .gpo_val_i (cfg_i[CFG_GPO_LSB +: BYTE_W]),
      .lo_eff_i  (lo_eff),
      .port_b_o  (port_b_o)
   );

   omx_qual_route #(.REG_QUAL(REG_QUAL)) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .to_tdo_i (cfg_i[CFG_QUAL_TDO]),
      .vbi_i    (vbi_act_i),
      .vid_i    (vid_act_i),
      .vact_o   (vact_o),
      .tdo_o    (tdo_o)
   );

   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (port_a_o == '0 && port_b_o == '0 && !tdo_o)); // R9
endmodule

// File: tb/test_outport_mux.sv
`timescale 1ns/1ps
module test_outport_mux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pix_word_i = '0;
   logic        word_stb_i = 1'b0;
   logic [10:0] cfg_i = '0;
   logic        vbi_act_i = 1'b0;
   logic        vid_act_i = 1'b0;
   logic [7:0]  port_a_o, port_b_o;
   logic        vact_o, tdo_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int held = 0;
   int exp_a = 0, exp_b = 0, exp_v = 0, exp_t = 0;
   string lbl_a = "R9", lbl_b = "R9", lbl_q = "R9";

   always #4 clk = ~clk;

   outport_mux i_outport_mux (
      .clk(clk), .rst_n(rst_n), .pix_word_i(pix_word_i), .word_stb_i(word_stb_i),
      .cfg_i(cfg_i), .vbi_act_i(vbi_act_i), .vid_act_i(vid_act_i),
      .port_a_o(port_a_o), .port_b_o(port_b_o), .vact_o(vact_o), .tdo_o(tdo_o)
   );

   task automatic check(input string lbl, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", lbl, what, act, exp, $time);
      end
   endtask

   // Compare outputs of the last edge, drive new inputs, predict the next edge.
   task automatic step(input bit rst, input bit stb, input logic [15:0] w,
                       input logic [10:0] cfg, input bit vbi, input bit vid);
      @(negedge clk);
      check(lbl_a, "port_a", int'(port_a_o), exp_a);
      check(lbl_b, "port_b", int'(port_b_o), exp_b);
      check(lbl_q, "vact",   int'(vact_o),   exp_v);
      check(lbl_q, "tdo",    int'(tdo_o),    exp_t);
      rst_n = !rst; word_stb_i = stb; pix_word_i = w; cfg_i = cfg;
      vbi_act_i = vbi; vid_act_i = vid;
      if (rst) begin
         held = 0; exp_a = 0; exp_b = 0; exp_v = 0; exp_t = 0;
         lbl_a = "R9"; lbl_b = "R9"; lbl_q = "R9";
      end else begin
         int weff;
         weff = stb ? int'(w) : held;
         if (stb) held = int'(w);
         if (cfg[0]) begin
            exp_a = stb ? (weff >> 8) : (weff & 255);
            lbl_a = stb ? "R8" : "R2";
            exp_b = cfg[1] ? int'(cfg[10:3]) : 0;
            lbl_b = cfg[1] ? "R3" : "R5";
         end else begin
            exp_a = weff >> 8;
            lbl_a = "R1";
            exp_b = weff & 255;
            lbl_b = "R4";
         end
         exp_v = cfg[2] ? int'(vid) : int'(vbi);
         exp_t = cfg[2] ? int'(vbi) : 0;
         lbl_q = cfg[2] ? "R6" : "R7";
      end
   endtask

   initial begin
      // R9: reset state, then idle with no strobe
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 16'hBEEF, 11'h7FF, 1'b1, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 16'h1234, 11'h000, 1'b0, 1'b0);
      // Directed: double mode, back-to-back strobes (R8), then hold low byte (R2)
      step(1'b0, 1'b1, 16'hA1B2, 11'h001, 1'b0, 1'b0);
      step(1'b0, 1'b1, 16'hC3D4, 11'h001, 1'b0, 1'b0);
      step(1'b0, 1'b0, 16'h0000, 11'h001, 1'b0, 1'b0);
      step(1'b0, 1'b0, 16'h0000, 11'h001, 1'b0, 1'b0);
      // Single mode ignores general-output fields (R4)
      step(1'b0, 1'b1, 16'h5A6B, {8'hFF, 3'b010}, 1'b1, 1'b0);
      step(1'b0, 1'b0, 16'h0000, {8'h00, 3'b110}, 1'b1, 1'b0);
      // Random phases over modes, strobe spacings and routing
      for (int ph = 0; ph < 12; ph++) begin
         int per;
         per = 1 + (ph % 3);
         for (int c = 0; c < 300; c++) begin
            logic [10:0] cfg;
            cfg = 11'($urandom);
            cfg[0] = ph[0];
            if (ph >= 8) cfg[0] = 1'($urandom);
            step(1'b0, (c % per) == 0, 16'($urandom), cfg, 1'($urandom), 1'($urandom));
         end
      end
      // Reset again mid-stream (R9)
      step(1'b1, 1'b1, 16'hFFFF, 11'h7FF, 1'b1, 1'b1);
      step(1'b0, 1'b0, 16'h0000, 11'h001, 1'b0, 1'b0);
      step(1'b0, 1'b0, 16'h0000, 11'h000, 1'b0, 1'b0);
      step(1'b0, 1'b0, 16'h0000, 11'h000, 1'b0, 1'b0);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule